// File: doc/BRIEF.md
# DMA descriptor sequencing controller

This block runs scatter-gather DMA jobs on behalf of a host. The host sets up a job through a 32-bit single-beat register slave: where the descriptor list lives in host memory, how many descriptors it has, where the completion word must go, and which way the data moves. Writing the start bit makes the controller ask the read mover to bring the descriptor list in. The fetched descriptors come back as 256-bit beats on a table port and are stored in one of two local tables, one per direction.

Once the whole list is stored, the controller hands the descriptors one at a time, in table order, to the mover for the job's direction. Host-to-local jobs go to the read mover and local-to-host jobs go to the write mover. It starts the next descriptor only after the chosen mover reports done. After the last descriptor it writes one 32-bit status word to host memory through a write-only single-beat master. Only then does it raise a one-cycle MSI request, and it returns to idle when the PCIe core acknowledges that request.

Top module: `dma_desc_sequencer`

## Requirements
- R1: After reset, fetchValid, rdMvValid, wrMvValid, stWrite and msiReq are low, and register words 0 to 4 all read 0.
- R2: A register read returns its data on regRdata one cycle after regRead. Word 1 (table address) and word 3 (status address) read back the value last written. Word 2 (descriptor count) reads back the written value, but a value above the table depth (128) is stored as 128. Word 0 bit 1 reads the direction of the latest job.
- R3: A write to word 0 with bit 0 set, made while idle, starts a job, and bit 1 gives the direction (0 host-to-local, 1 local-to-host). In the cycle after that write, fetchValid rises with fetchAddr set to the table address, fetchCount set to the count and fetchSel set to the direction. It stays high until the cycle in which fetchReady is high, and it is low after that cycle.
- R4: A table beat with tblWrite high and no burst in progress starts a burst. Its entry is tblAddr in the table chosen by tblSel (0 read table, 1 write table), and tblBurst (1 to 16) gives the number of beats. The later beats of the burst fill the following entries, and the values on tblAddr, tblSel and tblBurst during those beats are ignored. No descriptor is dispatched before as many beats as the count have arrived since the start.
- R5: Descriptors are dispatched in table order starting at entry 0. The field positions are: source in bits 31:0, destination in bits 63:32, length in dwords in bits 87:64 and ID in bits 103:96. All other bits are ignored. Only the mover for the job's direction sees a valid command, and mvSrc, mvDst, mvLen and mvId carry that entry's fields.
- R6: After a command is accepted, no further command is issued until the selected mover pulses its done input. A done pulse from the other mover has no effect.
- R7: After the last done, or straight after the fetch when the count is 0, stWrite goes high with stAddr set to the status address. The status word is: bit 31 = 1, bit 16 = direction, bits 15:8 = count, bits 7:0 = ID of the last descriptor completed (0 if none). The request and its address and data stay stable while stWaitReq is high.
- R8: msiReq is high for exactly one cycle, namely the cycle after the status write is accepted (stWrite high and stWaitReq low). The controller stays busy (word 4 bit 0 = 1) until msiAck is seen.
- R9: A start write made while busy, including in the very cycle msiAck arrives, starts no job and sets the sticky error bit (word 4 bit 1). Writing 1 to word 4 bit 1 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word index |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, one cycle after regRead |
| fetchValid | output | 1 | Descriptor list fetch request to read mover |
| fetchReady | input | 1 | Fetch request accepted |
| fetchSel | output | 1 | Table the fetched list must land in |
| fetchAddr | output | 32 | Host address of descriptor list |
| fetchCount | output | 8 | Number of descriptors to fetch |
| tblWrite | input | 1 | Table beat valid |
| tblSel | input | 1 | Table select on first burst beat |
| tblAddr | input | 7 | Entry index on first burst beat |
| tblBurst | input | 5 | Burst length on first burst beat |
| tblData | input | 256 | One descriptor per beat |
| rdMvValid | output | 1 | Command to read mover |
| rdMvReady | input | 1 | Read mover accepts command |
| rdMvDone | input | 1 | Read mover done pulse |
| wrMvValid | output | 1 | Command to write mover |
| wrMvReady | input | 1 | Write mover accepts command |
| wrMvDone | input | 1 | Write mover done pulse |
| mvSrc | output | 32 | Command source address |
| mvDst | output | 32 | Command destination address |
| mvLen | output | 24 | Command length in dwords |
| mvId | output | 8 | Command descriptor ID |
| stWrite | output | 1 | Status word write request |
| stWaitReq | input | 1 | Status write stall |
| stAddr | output | 32 | Status word host address |
| stData | output | 32 | Status word |
| msiReq | output | 1 | Interrupt request pulse |
| msiAck | input | 1 | Interrupt acknowledge |

## Verification
Two functions can land in the same cycle. The first pair is a host start write arriving in the very cycle msiAck returns the controller to idle. The bench drives both on one clock and then reads the error bit back as set and checks that no fetch request follows, since at that edge the controller was still busy. The second pair is a done pulse from the mover that was not selected arriving while the selected mover's transfer is still open. The bench sends that pulse and then requires that no further command appears until the real done pulse arrives. A scoreboard queue holds the expected commands in table order, and a monitor compares every command the controller issues against the queue.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DISPATCH,
    ST_WAIT_DONE,
    ST_STATUS_WR,
    ST_MSI
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchJob;
    logic setErr;
    logic doneAccept;
  } seqStrobe_t;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_TABLE  = 3'd1;
  localparam logic [2:0] REG_COUNT  = 3'd2;
  localparam logic [2:0] REG_STADDR = 3'd3;
  localparam logic [2:0] REG_STAT   = 3'd4;

endpackage

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DESC_W    = 256,
  parameter int DEPTH     = 128,
  parameter int LEN_W     = 24,
  parameter int ID_W      = 8,
  parameter int BURST_W   = 5,
  parameter int MAX_BURST = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regWrite,
  input  logic               regRead,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic               tblWrite,
  input  logic               tblSel,
  input  logic [IDX_W-1:0]   tblAddr,
  input  logic [BURST_W-1:0] tblBurst,
  input  logic [DESC_W-1:0]  tblData,
  input  seqStrobe_t         strobe,
  input  logic               busy,
  output logic               startReq,
  output logic               dir,
  output logic [ADDR_W-1:0]  jobTableAddr,
  output logic [CNT_W-1:0]   jobCount,
  output logic [ADDR_W-1:0]  jobStatusAddr,
  output logic               allFetched,
  output logic               countZero,
  output logic               lastIdx,
  output logic [ADDR_W-1:0]  curSrc,
  output logic [ADDR_W-1:0]  curDst,
  output logic [LEN_W-1:0]   curLen,
  output logic [ID_W-1:0]    curId,
  output logic [31:0]        statusWord
);

  localparam int SRC_LSB = 0;
  localparam int DST_LSB = 32;
  localparam int LEN_LSB = 64;
  localparam int ID_LSB  = 96;
  localparam int NUM_TBL = 2;

  logic [ADDR_W-1:0]  tableAddrQ, statusAddrQ;
  logic [CNT_W-1:0]   countQ, countWr;
  logic               dirQ, errQ;
  logic [CNT_W-1:0]   beatsQ;
  logic [IDX_W-1:0]   idxQ;
  logic [ID_W-1:0]    lastIdQ;
  logic [BURST_W-1:0] burstLeftQ;
  logic [IDX_W-1:0]   burstPtrQ, beatPtr;
  logic               burstSelQ, beatSel, beatFirst;
  logic [31:0]        rdMux;
  logic               unusedDescBits;

  assign unusedDescBits = ^{tblData[DESC_W-1:ID_LSB+ID_W], tblData[ID_LSB-1:LEN_LSB+LEN_W]};

  assign startReq = regWrite && (regAddr == REG_CTRL) && regWdata[0];
  assign countWr  = (regWdata > 32'(DEPTH)) ? CNT_W'(DEPTH) : regWdata[CNT_W-1:0];

  // host register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableAddrQ  <= '0;
      statusAddrQ <= '0;
      countQ      <= '0;
      errQ        <= 1'b0;
    end else begin
      if (regWrite && regAddr == REG_TABLE)  tableAddrQ  <= regWdata[ADDR_W-1:0];
      if (regWrite && regAddr == REG_STADDR) statusAddrQ <= regWdata[ADDR_W-1:0];
      if (regWrite && regAddr == REG_COUNT)  countQ      <= countWr;
      if (strobe.setErr) errQ <= 1'b1;
      else if (regWrite && regAddr == REG_STAT && regWdata[1]) errQ <= 1'b0;
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (regAddr)
      REG_CTRL:   rdMux[1] = dirQ;
      REG_TABLE:  rdMux[ADDR_W-1:0] = tableAddrQ;
      REG_COUNT:  rdMux[CNT_W-1:0] = countQ;
      REG_STADDR: rdMux[ADDR_W-1:0] = statusAddrQ;
      REG_STAT:   rdMux[1:0] = {errQ, busy};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else if (regRead) regRdata <= rdMux;
  end

  // job snapshot taken at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ          <= 1'b0;
      jobTableAddr  <= '0;
      jobCount      <= '0;
      jobStatusAddr <= '0;
    end else if (strobe.latchJob) begin
      dirQ          <= regWdata[1];
      jobTableAddr  <= tableAddrQ;
      jobCount      <= countQ;
      jobStatusAddr <= statusAddrQ;
    end
  end

  // burst tracking on the table port
  assign beatFirst = (burstLeftQ == '0);
  assign beatPtr   = beatFirst ? tblAddr : burstPtrQ;
  assign beatSel   = beatFirst ? tblSel  : burstSelQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstLeftQ <= '0;
      burstPtrQ  <= '0;
      burstSelQ  <= 1'b0;
    end else if (tblWrite) begin
      burstPtrQ <= beatPtr + 1'b1;
      burstSelQ <= beatSel;
      if (beatFirst) burstLeftQ <= (tblBurst == '0) ? '0 : tblBurst - 1'b1;
      else           burstLeftQ <= burstLeftQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.latchJob) beatsQ <= '0;
    else if (tblWrite && beatsQ != '1) beatsQ <= beatsQ + 1'b1;
  end

  // one descriptor table per direction, decoded fields only
  logic [NUM_TBL-1:0][ADDR_W-1:0] rdSrc, rdDst;
  logic [NUM_TBL-1:0][LEN_W-1:0]  rdLen;
  logic [NUM_TBL-1:0][ID_W-1:0]   rdId;

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic [ADDR_W-1:0] srcMem [DEPTH];
    logic [ADDR_W-1:0] dstMem [DEPTH];
    logic [LEN_W-1:0]  lenMem [DEPTH];
    logic [ID_W-1:0]   idMem  [DEPTH];

    always_ff @(posedge clk) begin
      if (tblWrite && beatSel == 1'(t)) begin
        srcMem[beatPtr] <= tblData[SRC_LSB +: ADDR_W];
        dstMem[beatPtr] <= tblData[DST_LSB +: ADDR_W];
        lenMem[beatPtr] <= tblData[LEN_LSB +: LEN_W];
        idMem[beatPtr]  <= tblData[ID_LSB  +: ID_W];
      end
    end

    assign rdSrc[t] = srcMem[idxQ];
    assign rdDst[t] = dstMem[idxQ];
    assign rdLen[t] = lenMem[idxQ];
    assign rdId[t]  = idMem[idxQ];
  end

  assign curSrc = rdSrc[dirQ];
  assign curDst = rdDst[dirQ];
  assign curLen = rdLen[dirQ];
  assign curId  = rdId[dirQ];

  // dispatch pointer and completion record
  always_ff @(posedge clk) begin
    if (!rstN || strobe.latchJob) begin
      idxQ    <= '0;
      lastIdQ <= '0;
    end else if (strobe.doneAccept) begin
      idxQ    <= idxQ + 1'b1;
      lastIdQ <= curId;
    end
  end

  assign dir        = dirQ;
  assign allFetched = (beatsQ >= jobCount);
  assign countZero  = (jobCount == '0);
  assign lastIdx    = ({1'b0, idxQ} == jobCount - 1'b1);

  always_comb begin
    statusWord        = '0;
    statusWord[31]    = 1'b1;
    statusWord[16]    = dirQ;
    statusWord[15:8]  = 8'(jobCount);
    statusWord[7:0]   = 8'(lastIdQ);
  end

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tblWrite && beatFirst) |-> (tblBurst <= BURST_W'(MAX_BURST)));

  // R2
  count_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH));

endmodule

// File: rtl/dma_seq_control.sv
module dma_seq_control
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       dir,
  input  logic       allFetched,
  input  logic       countZero,
  input  logic       lastIdx,
  input  logic       fetchReady,
  input  logic       rdMvReady,
  input  logic       rdMvDone,
  input  logic       wrMvReady,
  input  logic       wrMvDone,
  input  logic       stWaitReq,
  input  logic       msiAck,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       fetchValid,
  output logic       rdMvValid,
  output logic       wrMvValid,
  output logic       stWrite,
  output logic       msiReq
);

  seqState_t stateQ, stateD;
  logic      fetchSentQ, msiSentQ;
  logic      mvAccept, selDone;

  assign busy       = (stateQ != ST_IDLE);
  assign fetchValid = (stateQ == ST_FETCH) && !fetchSentQ;
  assign rdMvValid  = (stateQ == ST_DISPATCH) && !dir;
  assign wrMvValid  = (stateQ == ST_DISPATCH) && dir;
  assign stWrite    = (stateQ == ST_STATUS_WR);
  assign msiReq     = (stateQ == ST_MSI) && !msiSentQ;
  assign mvAccept   = (rdMvValid && rdMvReady) || (wrMvValid && wrMvReady);
  assign selDone    = dir ? wrMvDone : rdMvDone;

  always_comb begin
    strobe.latchJob   = startReq && (stateQ == ST_IDLE);
    strobe.setErr     = startReq && (stateQ != ST_IDLE);
    strobe.doneAccept = (stateQ == ST_WAIT_DONE) && selDone;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:      if (strobe.latchJob) stateD = ST_FETCH;
      ST_FETCH:     if (fetchSentQ && allFetched)
                      stateD = countZero ? ST_STATUS_WR : ST_DISPATCH;
      ST_DISPATCH:  if (mvAccept) stateD = ST_WAIT_DONE;
      ST_WAIT_DONE: if (selDone) stateD = lastIdx ? ST_STATUS_WR : ST_DISPATCH;
      ST_STATUS_WR: if (!stWaitReq) stateD = ST_MSI;
      ST_MSI:       if (msiAck) stateD = ST_IDLE;
      default:      stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      fetchSentQ <= 1'b0;
      msiSentQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobe.latchJob) fetchSentQ <= 1'b0;
      else if (fetchValid && fetchReady) fetchSentQ <= 1'b1;
      msiSentQ <= (stateD == ST_MSI) && (msiSentQ || msiReq);
    end
  end

  // R3
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchReady) |=> fetchValid);

  // R5
  one_mover_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdMvValid && wrMvValid));

  // R6
  dispatch_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    mvAccept |=> !(rdMvValid || wrMvValid));

  // R8
  msi_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    msiReq |=> !msiReq);

  // R8
  msi_after_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msiReq) |-> $past(stWrite && !stWaitReq));

endmodule

// File: rtl/dma_desc_sequencer.sv
module dma_desc_sequencer
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DESC_W    = 256,
  parameter int DEPTH     = 128,
  parameter int LEN_W     = 24,
  parameter int ID_W      = 8,
  parameter int BURST_W   = 5,
  parameter int MAX_BURST = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regWrite,
  input  logic               regRead,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic               fetchValid,
  input  logic               fetchReady,
  output logic               fetchSel,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [CNT_W-1:0]   fetchCount,
  input  logic               tblWrite,
  input  logic               tblSel,
  input  logic [IDX_W-1:0]   tblAddr,
  input  logic [BURST_W-1:0] tblBurst,
  input  logic [DESC_W-1:0]  tblData,
  output logic               rdMvValid,
  input  logic               rdMvReady,
  input  logic               rdMvDone,
  output logic               wrMvValid,
  input  logic               wrMvReady,
  input  logic               wrMvDone,
  output logic [ADDR_W-1:0]  mvSrc,
  output logic [ADDR_W-1:0]  mvDst,
  output logic [LEN_W-1:0]   mvLen,
  output logic [ID_W-1:0]    mvId,
  output logic               stWrite,
  input  logic               stWaitReq,
  output logic [ADDR_W-1:0]  stAddr,
  output logic [31:0]        stData,
  output logic               msiReq,
  input  logic               msiAck
);

  seqStrobe_t strobe;
  logic       startReq, busy, dir, allFetched, countZero, lastIdx;

  dma_seq_datapath #(
    .ADDR_W(ADDR_W), .DESC_W(DESC_W), .DEPTH(DEPTH), .LEN_W(LEN_W),
    .ID_W(ID_W), .BURST_W(BURST_W), .MAX_BURST(MAX_BURST)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrite(regWrite), .regRead(regRead),
    .regWdata(regWdata), .regRdata(regRdata),
    .tblWrite(tblWrite), .tblSel(tblSel), .tblAddr(tblAddr),
    .tblBurst(tblBurst), .tblData(tblData),
    .strobe(strobe), .busy(busy), .startReq(startReq), .dir(dir),
    .jobTableAddr(fetchAddr), .jobCount(fetchCount), .jobStatusAddr(stAddr),
    .allFetched(allFetched), .countZero(countZero), .lastIdx(lastIdx),
    .curSrc(mvSrc), .curDst(mvDst), .curLen(mvLen), .curId(mvId),
    .statusWord(stData)
  );

  dma_seq_control ctl_i (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .dir(dir), .allFetched(allFetched),
    .countZero(countZero), .lastIdx(lastIdx),
    .fetchReady(fetchReady),
    .rdMvReady(rdMvReady), .rdMvDone(rdMvDone),
    .wrMvReady(wrMvReady), .wrMvDone(wrMvDone),
    .stWaitReq(stWaitReq), .msiAck(msiAck),
    .strobe(strobe), .busy(busy), .fetchValid(fetchValid),
    .rdMvValid(rdMvValid), .wrMvValid(wrMvValid),
    .stWrite(stWrite), .msiReq(msiReq)
  );

  assign fetchSel = dir;

  // R7
  st_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stWrite && stWaitReq) |=> (stWrite && $stable(stData) && $stable(stAddr)));

endmodule

// File: tb/dma_desc_sequencer_tb_top.sv
module dma_desc_sequencer_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   regAddr = '0;
  logic         regWrite = 1'b0, regRead = 1'b0;
  logic [31:0]  regWdata = '0, regRdata;
  logic         fetchValid, fetchReady = 1'b0, fetchSel;
  logic [31:0]  fetchAddr;
  logic [7:0]   fetchCount;
  logic         tblWrite = 1'b0, tblSel = 1'b0;
  logic [6:0]   tblAddr = '0;
  logic [4:0]   tblBurst = '0;
  logic [255:0] tblData = '0;
  logic         rdMvValid, wrMvValid;
  logic         rdMvReady = 1'b1, wrMvReady = 1'b1;
  logic         rdMvDone = 1'b0, wrMvDone = 1'b0;
  logic [31:0]  mvSrc, mvDst;
  logic [23:0]  mvLen;
  logic [7:0]   mvId;
  logic         stWrite, stWaitReq = 1'b1;
  logic [31:0]  stAddr, stData;
  logic         msiReq, msiAck = 1'b0;

  int errors = 0;
  int checks = 0;

  typedef struct packed {
    logic        dir;
    logic [31:0] src;
    logic [31:0] dst;
    logic [23:0] len;
    logic [7:0]  id;
  } expCmd_t;

  expCmd_t expQ[$];

  always #2.5 clk = ~clk;

  dma_desc_sequencer dut_i (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrite(regWrite), .regRead(regRead),
    .regWdata(regWdata), .regRdata(regRdata),
    .fetchValid(fetchValid), .fetchReady(fetchReady), .fetchSel(fetchSel),
    .fetchAddr(fetchAddr), .fetchCount(fetchCount),
    .tblWrite(tblWrite), .tblSel(tblSel), .tblAddr(tblAddr),
    .tblBurst(tblBurst), .tblData(tblData),
    .rdMvValid(rdMvValid), .rdMvReady(rdMvReady), .rdMvDone(rdMvDone),
    .wrMvValid(wrMvValid), .wrMvReady(wrMvReady), .wrMvDone(wrMvDone),
    .mvSrc(mvSrc), .mvDst(mvDst), .mvLen(mvLen), .mvId(mvId),
    .stWrite(stWrite), .stWaitReq(stWaitReq), .stAddr(stAddr), .stData(stData),
    .msiReq(msiReq), .msiAck(msiAck)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic expCmd_t mkCmd(input bit d, input int i, input logic [7:0] baseId);
    expCmd_t c;
    c.dir = d;
    c.src = 32'h1000_0000 + (32'(d) << 24) + 32'(i) * 64;
    c.dst = 32'h2000_0000 + 32'(i) * 128;
    c.len = 24'(i + 5);
    c.id  = baseId + 8'(i);
    return c;
  endfunction

  function automatic logic [255:0] packDesc(input expCmd_t c);
    logic [255:0] d;
    d = {8{32'hDEAD_BEEF}};
    d[31:0]   = c.src;
    d[63:32]  = c.dst;
    d[87:64]  = c.len;
    d[103:96] = c.id;
    return d;
  endfunction

  // scoreboard monitor: every issued command is popped and compared (R5)
  always @(negedge clk) begin
    if (rstN && (rdMvValid || wrMvValid)) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R5 unexpected command", 64'(mvId), 64'hFF);
      end else begin
        expCmd_t e;
        e = expQ.pop_front();
        chk(wrMvValid == e.dir && rdMvValid == !e.dir, "R5 mover select",
            64'({rdMvValid, wrMvValid}), 64'({!e.dir, e.dir}));
        chk(mvSrc == e.src && mvDst == e.dst, "R5 addresses",
            {mvSrc, mvDst}, {e.src, e.dst});
        chk(mvLen == e.len && mvId == e.id, "R5 length and id",
            64'({mvLen, mvId}), 64'({e.len, e.id}));
      end
    end
  end

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    regRead = 1'b1; regAddr = a;
    @(negedge clk);
    d = regRdata;
    regRead = 1'b0;
  endtask

  task automatic runJob(input bit d, input int count, input logic [7:0] baseId,
                        input bit midErr, input bit ackRace);
    logic [31:0] rd;
    logic [31:0] expSt;
    int guard;
    int sent;
    regWr(3'd1, 32'hA000_0000 + 32'(count));
    regWr(3'd2, 32'(count));
    regWr(3'd3, 32'hB000_0040 + 32'(d));
    regRd(3'd1, rd); chk(rd == 32'hA000_0000 + 32'(count), "R2 table address readback", 64'(rd), 64'(32'hA000_0000 + 32'(count)));
    regRd(3'd2, rd); chk(rd == 32'(count), "R2 count readback", 64'(rd), 64'(count));
    regRd(3'd3, rd); chk(rd == 32'hB000_0040 + 32'(d), "R2 status address readback", 64'(rd), 64'(32'hB000_0040 + 32'(d)));
    for (int i = 0; i < count; i++) expQ.push_back(mkCmd(d, i, baseId));

    regWr(3'd0, {30'd0, d, 1'b1});
    chk(fetchValid == 1'b1, "R3 fetch request raised", 64'(fetchValid), 64'd1);
    chk(fetchAddr == 32'hA000_0000 + 32'(count) && fetchCount == 8'(count) && fetchSel == d,
        "R3 fetch fields", {fetchAddr, 24'(fetchCount), 8'(fetchSel)},
        {32'hA000_0000 + 32'(count), 24'(count), 8'(d)});
    @(negedge clk);
    chk(fetchValid == 1'b1, "R3 fetch held without ready", 64'(fetchValid), 64'd1);
    fetchReady = 1'b1;
    @(negedge clk);
    fetchReady = 1'b0;
    chk(fetchValid == 1'b0, "R3 fetch dropped after ready", 64'(fetchValid), 64'd0);

    sent = 0;
    while (sent < count) begin
      int bl;
      bl = (count - sent > 16) ? 16 : count - sent;
      for (int b = 0; b < bl; b++) begin
        chk(!rdMvValid && !wrMvValid, "R4 no dispatch before list complete",
            64'({rdMvValid, wrMvValid}), 64'd0);
        tblWrite = 1'b1;
        tblSel   = (b == 0) ? d : !d;
        tblAddr  = (b == 0) ? 7'(sent) : 7'h55;
        tblBurst = (b == 0) ? 5'(bl) : 5'd3;
        tblData  = packDesc(mkCmd(d, sent + b, baseId));
        @(negedge clk);
      end
      tblWrite = 1'b0;
      sent += bl;
    end

    for (int i = 0; i < count; i++) begin
      guard = 0;
      while (!(rdMvValid || wrMvValid) && guard < 20) begin
        @(negedge clk);
        guard++;
      end
      chk(guard < 20, "R5 command issued", 64'(guard), 64'd0);
      @(negedge clk);
      chk(!rdMvValid && !wrMvValid, "R6 no command while waiting", 64'({rdMvValid, wrMvValid}), 64'd0);
      if (i == 0) begin
        if (d) rdMvDone = 1'b1; else wrMvDone = 1'b1;
        @(negedge clk);
        rdMvDone = 1'b0; wrMvDone = 1'b0;
        @(negedge clk);
        chk(!rdMvValid && !wrMvValid && !stWrite, "R6 other mover done ignored",
            64'({rdMvValid, wrMvValid, stWrite}), 64'd0);
        if (midErr) regWr(3'd0, {30'd0, !d, 1'b1});
      end
      if (d) wrMvDone = 1'b1; else rdMvDone = 1'b1;
      @(negedge clk);
      rdMvDone = 1'b0; wrMvDone = 1'b0;
    end

    guard = 0;
    while (!stWrite && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    expSt = 32'h8000_0000 | (32'(d) << 16) | (32'(count & 255) << 8) |
            ((count == 0) ? 32'd0 : 32'(baseId + 8'(count - 1)));
    chk(stWrite == 1'b1, "R7 status write issued", 64'(stWrite), 64'd1);
    chk(stAddr == 32'hB000_0040 + 32'(d), "R7 status address", 64'(stAddr), 64'(32'hB000_0040 + 32'(d)));
    chk(stData == expSt, "R7 status word", 64'(stData), 64'(expSt));
    chk(msiReq == 1'b0, "R8 no interrupt before status write", 64'(msiReq), 64'd0);
    @(negedge clk);
    chk(stWrite == 1'b1 && stData == expSt, "R7 status held under stall", 64'({stWrite, stData}), 64'({1'b1, expSt}));
    stWaitReq = 1'b0;
    @(negedge clk);
    stWaitReq = 1'b1;
    chk(stWrite == 1'b0 && msiReq == 1'b1, "R8 interrupt after status write", 64'({stWrite, msiReq}), 64'b01);
    @(negedge clk);
    chk(msiReq == 1'b0, "R8 interrupt is one cycle", 64'(msiReq), 64'd0);
    regRd(3'd4, rd);
    chk(rd[0] == 1'b1, "R8 busy until acknowledge", 64'(rd[0]), 64'd1);
    if (ackRace) begin
      regWrite = 1'b1; regAddr = 3'd0; regWdata = 32'h1;
      msiAck = 1'b1;
      @(negedge clk);
      regWrite = 1'b0; msiAck = 1'b0;
      @(negedge clk);
      chk(fetchValid == 1'b0, "R9 start during acknowledge ignored", 64'(fetchValid), 64'd0);
    end else begin
      msiAck = 1'b1;
      @(negedge clk);
      msiAck = 1'b0;
    end
    regRd(3'd4, rd);
    chk(rd == ((midErr || ackRace) ? 32'd2 : 32'd0), "R9 error bit after job",
        64'(rd), 64'((midErr || ackRace) ? 2 : 0));
    if (midErr || ackRace) begin
      regWr(3'd4, 32'd2);
      regRd(3'd4, rd);
      chk(rd == 32'd0, "R9 error bit cleared", 64'(rd), 64'd0);
    end
    regRd(3'd0, rd);
    chk(rd[1] == d, "R2 direction readback", 64'(rd[1]), 64'(d));
    chk(expQ.size() == 0, "R5 all commands issued", 64'(expQ.size()), 64'd0);
  endtask

  bit wdFired = 1'b0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    wdFired = 1'b1;
  end

  initial begin : main
    logic [31:0] rd;
    fork
      begin
        repeat (5) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        // R1
        chk(!fetchValid && !rdMvValid && !wrMvValid && !stWrite && !msiReq, "R1 outputs after reset",
            64'({fetchValid, rdMvValid, wrMvValid, stWrite, msiReq}), 64'd0);
        for (int a = 0; a < 5; a++) begin
          regRd(3'(a), rd);
          chk(rd == 32'd0, "R1 register reset value", 64'(rd), 64'd0);
        end
        regWr(3'd2, 32'd300);
        regRd(3'd2, rd);
        chk(rd == 32'd128, "R2 count clamped to depth", 64'(rd), 64'd128);
        runJob(1'b0, 20, 8'h40, 1'b1, 1'b0);
        runJob(1'b1, 3, 8'h90, 1'b0, 1'b1);
        runJob(1'b0, 0, 8'h00, 1'b0, 1'b0);
      end
      begin
        wait (wdFired);
      end
    join_any
    if (wdFired) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule